// File: doc/BRIEF.md
# Right-Shift Sequencer with Early Exit

This block runs a fixed number of one-bit right shifts over a chain made of a one-bit carry, an accumulator word and a multiplier-style word. A pulse on `start` loads all three values. Each later cycle with `step_en` high moves the whole chain one place toward the low end, and a zero enters at the top. A remaining-steps counter begins at the width of the low word and falls by one on every step.

The run ends in one of two ways. When the counter runs out, the result is the accumulator and the low word placed side by side. When the low word turns all-zero before that, the block stops at once. It then reports the accumulator moved up by the number of steps already taken, with zeros above and below it. The result and `done` stay fixed until the next `start`. A fresh `start` restarts the block at any time, even during a run.

The alignment shifter comes in two variants, chosen by a parameter: a logarithmic stage network or a flat one-hot select.

Top module: `shift_seq_exit`

## Requirements
- R1: On a cycle with `start` high, the block loads `cy_in`, `acc_in` and `low_in`, sets the remaining count to LOW_W and the taken count to 0, and clears `done` unless `low_in` is zero.
- R2: Each cycle with a run active, `step_en` high and `start` low, the chain {carry, acc, low} moves right by one bit and a 0 enters the carry. While the run is active, `result` shows {acc, low}.
- R3: If the low word never reaches zero early, `done` rises on the clock edge of the LOW_W-th step. `result` is then {acc, low} as it stands after that step.
- R4: If the low word becomes zero after k steps, with 0 < k < LOW_W, `done` rises on that step's edge. `result` is then the acc word zero-extended to ACC_W+LOW_W bits and shifted left by k.
- R5: If `low_in` is zero at load, `done` rises on the load edge with k = 0. `result` is then the zero-extended `acc_in`.
- R6: `step_en` is ignored while no run is active, and also after `done`. `result` and `done` hold their values until the next `start`.
- R7: `start` wins over `step_en` in the same cycle: no step is taken on that edge. A `start` during a run discards that run and begins a new one with the new operands.
- R8: A synchronous active-high `rst` clears every register, so that `done` = 0 and `result` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load operands and begin a run |
| cy_in | input | 1 | Initial carry bit |
| acc_in | input | ACC_W | Initial accumulator word |
| low_in | input | LOW_W | Initial low word |
| step_en | input | 1 | Request one right shift this cycle |
| result | output | ACC_W+LOW_W | Final (or running) result |
| done | output | 1 | Run finished; result valid and frozen |

## Verification
`start` and `step_en` can meet in one cycle. The bench raises both on every load, so that a step taken by mistake on the load edge would shorten the count of steps to completion. The bench also restarts a run that is part way through, and the second run must end exactly as a clean run on the new operands would. A further collision happens when the last counted step is also the step that zeroes the low word. The full sweep of low-word values covers this case, and both end conditions must then give the same aligned result.

// File: rtl/shift_seq_pkg.sv
package shift_seq_pkg;
   typedef enum logic {
      ALIGN_LOG  = 1'b0,
      ALIGN_FLAT = 1'b1
   } align_kind_e;

   function automatic int count_width(input int n);
      return $clog2(n + 1);
   endfunction
endpackage

// File: rtl/shift_seq_chain.sv
module shift_seq_chain #(
   parameter int ACC_W = 8,
   parameter int LOW_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic             step,
   input  logic             cy_in,
   input  logic [ACC_W-1:0] acc_in,
   input  logic [LOW_W-1:0] low_in,
   output logic             cy_q,
   output logic [ACC_W-1:0] acc_q,
   output logic [LOW_W-1:0] low_q,
   output logic             low_zero,
   output logic             low_zero_next
);
   localparam int CHAIN_W = 1 + ACC_W + LOW_W;

   logic [CHAIN_W-1:0] chain_q;
   logic [CHAIN_W-1:0] chain_shifted;

   assign chain_shifted = {1'b0, chain_q[CHAIN_W-1:1]};

   always_ff @(posedge clk) begin
      if (rst)       chain_q <= '0;
      else if (load) chain_q <= {cy_in, acc_in, low_in};
      else if (step) chain_q <= chain_shifted;
   end

   assign cy_q          = chain_q[CHAIN_W-1];
   assign acc_q         = chain_q[LOW_W +: ACC_W];
   assign low_q         = chain_q[LOW_W-1:0];
   assign low_zero      = (low_q == '0);
   assign low_zero_next = (chain_shifted[LOW_W-1:0] == '0);

   assert_shift_R2: assert property (@(posedge clk) disable iff (rst)
      step |=> (acc_q[ACC_W-1] == $past(cy_q)) && !cy_q
               && (low_q[LOW_W-1] == $past(acc_q[0])));
   assert_load_R1: assert property (@(posedge clk) disable iff (rst)
      load |=> (acc_q == $past(acc_in)) && (low_q == $past(low_in))
               && (cy_q == $past(cy_in)));
   assert_idle_R6: assert property (@(posedge clk) disable iff (rst)
      (!load && !step) |=> $stable(chain_q));
endmodule

// File: rtl/shift_seq_counter.sv
module shift_seq_counter #(
   parameter int LOW_W = 8,
   parameter int CW    = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic          step,
   output logic [CW-1:0] taken_q,
   output logic          last_step
);
   logic [CW-1:0] remain_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         remain_q <= '0;
         taken_q  <= '0;
      end else if (load) begin
         remain_q <= CW'(LOW_W);
         taken_q  <= '0;
      end else if (step) begin
         remain_q <= remain_q - CW'(1);
         taken_q  <= taken_q + CW'(1);
      end
   end

   assign last_step = (remain_q == CW'(1));

   assert_countdown_R3: assert property (@(posedge clk) disable iff (rst)
      step |=> (remain_q == CW'($past(remain_q) - CW'(1)))
               && (taken_q == CW'($past(taken_q) + CW'(1))));
   assert_restart_R7: assert property (@(posedge clk) disable iff (rst)
      load |=> (taken_q == '0) && (remain_q == CW'(LOW_W)));
   assert_nowrap_R3: assert property (@(posedge clk) disable iff (rst)
      step |-> (remain_q != '0));
endmodule

// File: rtl/shift_seq_align.sv
module shift_seq_align
   import shift_seq_pkg::*;
#(
   parameter int          ACC_W = 8,
   parameter int          LOW_W = 8,
   parameter int          CW    = 4,
   parameter align_kind_e KIND  = ALIGN_LOG
) (
   input  logic [ACC_W-1:0]       acc,
   input  logic [LOW_W-1:0]       low,
   input  logic [CW-1:0]          taken,
   input  logic                   low_zero,
   output logic [ACC_W+LOW_W-1:0] result
);
   localparam int RW = ACC_W + LOW_W;

   logic [RW-1:0] acc_ext;
   logic [RW-1:0] aligned;

   assign acc_ext = {{LOW_W{1'b0}}, acc};

   generate
      if (KIND == ALIGN_LOG) begin : g_log
         logic [RW-1:0] stage [0:CW];
         assign stage[0] = acc_ext;
         for (genvar s = 0; s < CW; s++) begin : g_stage
            assign stage[s+1] = taken[s] ? (stage[s] << (2 ** s)) : stage[s];
         end
         assign aligned = stage[CW];
      end else begin : g_flat
         always_comb begin
            aligned = '0;
            for (int i = 0; i <= LOW_W; i++) begin
               if (taken == CW'(i)) aligned = acc_ext << i;
            end
         end
      end
   endgenerate

   assign result = low_zero ? aligned : {acc, low};

   always_comb begin
      if (low_zero && (taken == '0))
         assert_noshift_R5: assert (result == acc_ext);
   end
endmodule

// File: rtl/shift_seq_exit.sv
module shift_seq_exit
   import shift_seq_pkg::*;
#(
   parameter int          ACC_W = 8,
   parameter int          LOW_W = 8,
   parameter align_kind_e KIND  = ALIGN_LOG
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   start,
   input  logic                   cy_in,
   input  logic [ACC_W-1:0]       acc_in,
   input  logic [LOW_W-1:0]       low_in,
   input  logic                   step_en,
   output logic [ACC_W+LOW_W-1:0] result,
   output logic                   done
);
   localparam int CW = count_width(LOW_W);

   generate
      if (ACC_W < 1 || LOW_W < 2) begin : g_bad_cfg
         $error("shift_seq_exit: ACC_W must be >= 1 and LOW_W >= 2");
      end
   endgenerate

   logic             busy_q;
   logic             done_q;
   logic             step;
   logic             finish;
   logic             cy_q;
   logic [ACC_W-1:0] acc_q;
   logic [LOW_W-1:0] low_q;
   logic             low_zero;
   logic             low_zero_next;
   logic [CW-1:0]    taken_q;
   logic             last_step;

   assign step   = busy_q && step_en && !start;
   assign finish = low_zero_next || last_step;

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else if (start) begin
         busy_q <= (low_in != '0);
         done_q <= (low_in == '0);
      end else if (step) begin
         busy_q <= !finish;
         done_q <= finish;
      end
   end

   shift_seq_chain #(.ACC_W(ACC_W), .LOW_W(LOW_W)) u_chain (
      .clk(clk), .rst(rst), .load(start), .step(step),
      .cy_in(cy_in), .acc_in(acc_in), .low_in(low_in),
      .cy_q(cy_q), .acc_q(acc_q), .low_q(low_q),
      .low_zero(low_zero), .low_zero_next(low_zero_next)
   );

   shift_seq_counter #(.LOW_W(LOW_W), .CW(CW)) u_count (
      .clk(clk), .rst(rst), .load(start), .step(step),
      .taken_q(taken_q), .last_step(last_step)
   );

   shift_seq_align #(.ACC_W(ACC_W), .LOW_W(LOW_W), .CW(CW), .KIND(KIND)) u_align (
      .acc(acc_q), .low(low_q), .taken(taken_q), .low_zero(low_zero),
      .result(result)
   );

   assign done = done_q;

   assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
      (done_q && !start) |=> done_q && $stable(result));
   assert_early_R4: assert property (@(posedge clk) disable iff (rst)
      (step && low_zero_next) |=> done_q && !busy_q);
   assert_full_R3: assert property (@(posedge clk) disable iff (rst)
      (step && last_step) |=> done_q);
   assert_excl_R6: assert property (@(posedge clk) disable iff (rst)
      !(busy_q && done_q));
   assert_chain_stop_R6: assert property (@(posedge clk) disable iff (rst)
      (!busy_q && !start) |=> $stable(cy_q) && $stable(taken_q));
endmodule

// File: tb/test_shift_seq_exit.sv
module test_shift_seq_exit;
   localparam int AW = 8;
   localparam int LW = 8;
   localparam int RW = AW + LW;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          start = 1'b0;
   logic          cy_in = 1'b0;
   logic [AW-1:0] acc_in = '0;
   logic [LW-1:0] low_in = '0;
   logic          step_en = 1'b0;
   logic [RW-1:0] result;
   logic          done;

   int n_run  = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   shift_seq_exit #(.ACC_W(AW), .LOW_W(LW)) i_shift_seq_exit (
      .clk(clk), .rst(rst), .start(start), .cy_in(cy_in), .acc_in(acc_in),
      .low_in(low_in), .step_en(step_en), .result(result), .done(done)
   );

   task automatic check(input bit ok, input string req, input logic [RW-1:0] act,
                        input logic [RW-1:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Reference: shift until low word zero or LW steps; zero exit aligns acc by k.
   task automatic model(input logic c, input logic [AW-1:0] a, input logic [LW-1:0] q,
                        output logic [RW-1:0] res, output int k);
      logic [AW+LW:0] ch;
      ch = {c, a, q};
      k  = 0;
      while (ch[LW-1:0] != '0 && k < LW) begin
         ch = ch >> 1;
         k++;
      end
      if (ch[LW-1:0] == '0) res = RW'(ch[LW +: AW]) << k;
      else                  res = ch[RW-1:0];
   endtask

   task automatic run_seq(input logic c, input logic [AW-1:0] a, input logic [LW-1:0] q,
                          input bit gaps);
      logic [RW-1:0] exp_res;
      int exp_k, steps, cyc;
      string tag;
      model(c, a, q, exp_res, exp_k);
      @(negedge clk);
      start = 1'b1; cy_in = c; acc_in = a; low_in = q; step_en = 1'b1;
      @(negedge clk);
      start = 1'b0;
      steps = 0; cyc = 0;
      while (!done && cyc < 40) begin
         step_en = gaps ? cyc[0] : 1'b1;
         @(negedge clk);
         if (step_en) steps++;
         cyc++;
      end
      step_en = 1'b0;
      tag = (q == '0) ? "R5" : (exp_k == LW) ? "R3" : "R4";
      check(done && result == exp_res, tag, result, exp_res);
      check(steps == exp_k, "R7 steps", RW'(steps), RW'(exp_k));
   endtask

   initial begin
      #(20 * 150000);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [RW-1:0] snap;
      logic [RW-1:0] er;
      int ek;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      check(done == 1'b0 && result == '0, "R8 reset", result, '0);

      // R6: step_en while idle
      step_en = 1'b1;
      repeat (3) @(negedge clk);
      step_en = 1'b0;
      check(done == 1'b0 && result == '0, "R6 idle", result, '0);

      // R2/R4 worked example
      @(negedge clk);
      start = 1'b1; cy_in = 1'b0; acc_in = 8'hD4; low_in = 8'h03;
      @(negedge clk);
      start = 1'b0;
      check(done == 1'b0 && result == 16'hD403, "R1 load", result, 16'hD403);
      step_en = 1'b1;
      @(negedge clk);
      check(done == 1'b0 && result == 16'h6A01, "R2 one step", result, 16'h6A01);
      @(negedge clk);
      step_en = 1'b0;
      check(done == 1'b1 && result == 16'h00D4, "R4 example", result, 16'h00D4);

      // R6: hold after done
      snap = result;
      step_en = 1'b1;
      repeat (4) @(negedge clk);
      step_en = 1'b0;
      check(done == 1'b1 && result == snap, "R6 hold", result, snap);

      // R2: carry enters acc MSB
      @(negedge clk);
      start = 1'b1; cy_in = 1'b1; acc_in = 8'h00; low_in = 8'h80;
      @(negedge clk);
      start = 1'b0; step_en = 1'b1;
      @(negedge clk);
      step_en = 1'b0;
      check(result == 16'h8040 && !done, "R2 carry", result, 16'h8040);

      // R7: restart mid-run
      @(negedge clk);
      start = 1'b1; cy_in = 1'b0; acc_in = 8'h11; low_in = 8'hF0;
      @(negedge clk);
      start = 1'b0; step_en = 1'b1;
      repeat (2) @(negedge clk);
      step_en = 1'b0;
      run_seq(1'b1, 8'hFF, 8'h80, 1'b0);
      model(1'b1, 8'hFF, 8'h80, er, ek);
      check(result == er, "R7 restart", result, er);

      // Sweep every low word with several acc/carry patterns
      for (int q = 0; q < 256; q++) begin
         run_seq(q[1], 8'hA5, LW'(q), q[0]);
         run_seq(~q[2], AW'(q * 7 + 3), LW'(q), 1'b0);
      end

      // R8: reset mid-run
      @(negedge clk);
      start = 1'b1; acc_in = 8'h3C; low_in = 8'h55;
      @(negedge clk);
      start = 1'b0; rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check(done == 1'b0 && result == '0, "R8 mid-run reset", result, '0);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule